// File: doc/BRIEF.md
# MESI snooping coherence controller

This block keeps a set of small private caches coherent with one another and with a word-addressed main memory. The caches share one snooping bus and use a four-state invalidate protocol: Modified, Exclusive, Shared and Invalid. Each core presents read or write requests through a ready/valid handshake. A round-robin arbiter picks one request per cycle, so all accesses fall into one global order. The whole bus transaction for that request is resolved in the cycle of the grant.

Each cache is direct-mapped and holds a block of several words per line. Coherence state is kept per block, so a write to one word of a block removes the block from every other cache. On a miss, a cache that already holds the block answers over the bus instead of memory. A cache that supplies a dirty block also writes it back. A Modified victim is written back when a fill replaces it.

Every completed request produces a done pulse with the resulting word and a trace record. The record gives the requester, the operation, the address, where the data came from, whether a bus transaction was needed, any write-backs, and the state that each cache now holds for the requested block. A reference model can check the run against this record.

Top module: `snoop_coherence_ctl`

## Requirements
- R1: After reset every cache line is Invalid, no done pulse or trace record is produced, and memory word a holds 0xA000 + a.
- R2: At most one request is granted per cycle (req_ready one-hot or zero). A request taken at a clock edge yields, in the next cycle, a one-cycle done pulse on that core with rdata and a trace record. rdata is the word read, or the word just written.
- R3: When several cores request together, grants rotate round-robin, starting with the core after the one granted last. After reset core 0 has first priority.
- R4: A read miss with no copy in any other cache fills from memory (trc_src = 1) and leaves the requester in Exclusive.
- R5: A read miss while other caches hold the block clean (Exclusive or Shared) takes the data from the lowest-indexed holder (trc_src = 2, trc_src_core = holder) without a write-back. The requester and all holders end in Shared.
- R6: A read miss while another cache holds the block Modified takes the data from that cache and writes the block back to memory (trc_wb = 1). Both caches end in Shared.
- R7: A read hit in M, E or S returns the cached word (trc_src = 0) with no bus transaction (trc_bus = 0), and no cache changes state.
- R8: A write hit in Modified or Exclusive updates the word with no bus transaction and leaves the requester in Modified.
- R9: A write hit in Shared broadcasts an invalidate (trc_bus = 1, trc_src = 0). Every other holder becomes Invalid and the requester becomes Modified.
- R10: A write miss is a read-with-intent-to-modify. Any holder supplies the block and becomes Invalid, and a Modified holder also writes back. The requester merges its word and ends in Modified. With no holder, the block comes from memory.
- R11: Coherence is per block. Address bit 0 selects the word within a block, bits 2:1 the line index and bits 5:3 the tag. A write to either word invalidates the whole block elsewhere, and the block keeps the other word's value.
- R12: When a miss replaces a Modified line holding a different tag, that line is written back to memory first (trc_evict_wb = 1). Replacing an Exclusive or Shared line is silent.

Trace state encoding, 2 bits per cache, with cache j at trc_states[2j+1:2j]: Invalid 0, Shared 1, Exclusive 2, Modified 3. A cache that does not hold the requested tag reports Invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCORES | Request valid, one bit per core |
| req_ready | output | NCORES | Grant; the request is taken at the edge where valid and ready are both high |
| req_write | input | NCORES | 1 = write, 0 = read, per core |
| req_addr | input | NCORES*ADDR_W | Word address, core j in slice j |
| req_wdata | input | NCORES*DATA_W | Write data, core j in slice j |
| done | output | NCORES | One-cycle completion pulse per core |
| rdata | output | DATA_W | Word returned with done |
| trc_valid | output | 1 | Trace record valid |
| trc_core | output | CORE_W | Requesting core |
| trc_write | output | 1 | Operation was a write |
| trc_addr | output | ADDR_W | Request address |
| trc_src | output | 2 | 0 local cache, 1 memory, 2 another cache |
| trc_src_core | output | CORE_W | Supplying cache when trc_src = 2, else 0 |
| trc_bus | output | 1 | A bus transaction was issued |
| trc_wb | output | 1 | Supplier wrote the requested block back |
| trc_evict_wb | output | 1 | Requester's Modified victim was written back |
| trc_states | output | 2*NCORES | Each cache's resulting state for the requested block |

## Verification
The hardest situation to reach from the ports is false sharing with a dirty owner: a block that is Modified in one cache after a write to one word, then written at its other word by a different core. That write must bring about a supply, a write-back and an invalidation in a single transaction. The stimulus builds it step by step. One core fills the block, writes it twice and hands it to a second core. A third core then joins from the neighbouring word, one sharer upgrades with an invalidate, and the original core writes the other word. The scoreboard checks the source, the write-back flag, every cache's state and the preserved neighbour word at each step. Eviction of a dirty line and round-robin order under three simultaneous requests are set up after that, from the known arbiter pointer.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_e;

  localparam logic [1:0] SRC_LOCAL = 2'd0;
  localparam logic [1:0] SRC_MEM   = 2'd1;
  localparam logic [1:0] SRC_CACHE = 2'd2;
endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int N = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] gidx
);
  logic [IW-1:0] last_q;

  always_comb begin
    grant = '0;
    gidx  = '0;
    for (int k = N; k >= 1; k--) begin : scan
      int c;
      c = int'(last_q) + k;
      if (c >= N) c = c - N;
      if (req[c]) begin
        grant    = '0;
        grant[c] = 1'b1;
        gidx     = IW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else if (|grant) last_q <= gidx;
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R3
  grant_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> ((grant & ~req) == '0 && (|grant)));
endmodule

// File: rtl/line_store.sv
module line_store import mesi_pkg::*; #(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 16,
  parameter int WPL    = 2,
  localparam int LINES = 1 << IDX_W,
  localparam int BW    = WPL * DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output line_st_e         st_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [BW-1:0]    blk_o,
  input  logic             we,
  input  line_st_e         st_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [BW-1:0]    blk_i
);
  line_st_e         st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];
  logic [BW-1:0]    blk_q [LINES];

  assign st_o  = st_q[idx];
  assign tag_o = tag_q[idx];
  assign blk_o = blk_q[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
        blk_q[i] <= '0;
      end
    end else if (we) begin
      st_q[idx]  <= st_i;
      tag_q[idx] <= tag_i;
      blk_q[idx] <= blk_i;
    end
  end
endmodule

// File: rtl/word_mem.sv
module word_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int OFF_W  = 1,
  localparam int BLK_W = ADDR_W - OFF_W,
  localparam int BLKS  = 1 << BLK_W,
  localparam int WPL   = 1 << OFF_W,
  localparam int BW    = WPL * DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] rd_blk,
  output logic [BW-1:0]    rd_data,
  input  logic             wa_en,
  input  logic [BLK_W-1:0] wa_blk,
  input  logic [BW-1:0]    wa_data,
  input  logic             wb_en,
  input  logic [BLK_W-1:0] wb_blk,
  input  logic [BW-1:0]    wb_data
);
  logic [BW-1:0] blk_q [BLKS];

  function automatic logic [DATA_W-1:0] init_word(int a);
    return DATA_W'(32'hA000 + a);
  endfunction

  assign rd_data = blk_q[rd_blk];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < BLKS; b++)
        for (int w = 0; w < WPL; w++)
          blk_q[b][w*DATA_W +: DATA_W] <= init_word(b * WPL + w);
    end else begin
      if (wa_en) blk_q[wa_blk] <= wa_data;
      if (wb_en) blk_q[wb_blk] <= wb_data;
    end
  end

  // R12
  port_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wa_en && wb_en && wa_blk == wb_blk));
endmodule

// File: rtl/snoop_coherence_ctl.sv
module snoop_coherence_ctl import mesi_pkg::*; #(
  parameter int NCORES = 3,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 1,
  localparam int CORE_W = (NCORES > 1) ? $clog2(NCORES) : 1,
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int BLK_W  = ADDR_W - OFF_W,
  localparam int WPL    = 1 << OFF_W,
  localparam int BW     = WPL * DATA_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCORES-1:0]        req_valid,
  output logic [NCORES-1:0]        req_ready,
  input  logic [NCORES-1:0]        req_write,
  input  logic [NCORES*ADDR_W-1:0] req_addr,
  input  logic [NCORES*DATA_W-1:0] req_wdata,
  output logic [NCORES-1:0]        done,
  output logic [DATA_W-1:0]        rdata,
  output logic                     trc_valid,
  output logic [CORE_W-1:0]        trc_core,
  output logic                     trc_write,
  output logic [ADDR_W-1:0]        trc_addr,
  output logic [1:0]               trc_src,
  output logic [CORE_W-1:0]        trc_src_core,
  output logic                     trc_bus,
  output logic                     trc_wb,
  output logic                     trc_evict_wb,
  output logic [2*NCORES-1:0]      trc_states
);
  // ---------------- helpers ----------------
  function automatic logic [CORE_W-1:0] first_set(logic [NCORES-1:0] v);
    logic [CORE_W-1:0] r;
    r = '0;
    for (int k = NCORES - 1; k >= 0; k--) if (v[k]) r = CORE_W'(k);
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] get_word(logic [BW-1:0] b, logic [OFF_W-1:0] o);
    return b[int'(o)*DATA_W +: DATA_W];
  endfunction

  function automatic logic [BW-1:0] put_word(logic [BW-1:0] b, logic [OFF_W-1:0] o,
                                             logic [DATA_W-1:0] d);
    logic [BW-1:0] r;
    r = b;
    r[int'(o)*DATA_W +: DATA_W] = d;
    return r;
  endfunction

  // ---------------- arbitration ----------------
  logic [NCORES-1:0] grant;
  logic [CORE_W-1:0] gidx;
  logic              take;

  rr_arbiter #(.N(NCORES)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid), .grant(grant), .gidx(gidx)
  );

  assign req_ready = grant;
  assign take      = |grant;

  // ---------------- selected request ----------------
  logic              cur_wr;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wd;
  logic [OFF_W-1:0]  off;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;

  assign cur_wr   = req_write[gidx];
  assign cur_addr = req_addr[int'(gidx)*ADDR_W +: ADDR_W];
  assign cur_wd   = req_wdata[int'(gidx)*DATA_W +: DATA_W];
  assign off      = cur_addr[OFF_W-1:0];
  assign idx      = cur_addr[OFF_W +: IDX_W];
  assign tag      = cur_addr[ADDR_W-1 -: TAG_W];

  // ---------------- cache arrays ----------------
  line_st_e         st    [NCORES];
  logic [TAG_W-1:0] tg    [NCORES];
  logic [BW-1:0]    blk   [NCORES];
  line_st_e         st_n  [NCORES];
  logic [TAG_W-1:0] tag_n [NCORES];
  logic [BW-1:0]    blk_n [NCORES];

  for (genvar g = 0; g < NCORES; g++) begin : g_cache
    line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .WPL(WPL)) u_lines (
      .clk(clk), .rst_n(rst_n), .idx(idx),
      .st_o(st[g]), .tag_o(tg[g]), .blk_o(blk[g]),
      .we(take), .st_i(st_n[g]), .tag_i(tag_n[g]), .blk_i(blk_n[g])
    );
  end

  // ---------------- memory ----------------
  logic [BW-1:0] mem_rd;
  logic          evict_wb, sup_wb;

  word_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .rd_blk({tag, idx}), .rd_data(mem_rd),
    .wa_en(evict_wb), .wa_blk({tg[gidx], idx}), .wa_data(blk[gidx]),
    .wb_en(sup_wb), .wb_blk({tag, idx}), .wb_data(blk[first_set(hold & ~grant)])
  );

  // ---------------- snoop decision (named events) ----------------
  logic [NCORES-1:0] hold, others;
  logic              own_hit, sup_v, sup_m, bus_use;
  logic [CORE_W-1:0] sup;
  line_st_e          own_st;
  logic [BW-1:0]     base_blk, new_blk;
  logic [1:0]        src;

  always_comb begin
    for (int j = 0; j < NCORES; j++)
      hold[j] = (st[j] != ST_I) && (tg[j] == tag);
    others   = hold & ~grant;
    own_hit  = hold[gidx];
    own_st   = st[gidx];
    sup_v    = |others;
    sup      = first_set(others);
    sup_m    = sup_v && (st[sup] == ST_M);
    evict_wb = take && !own_hit && (own_st == ST_M);
    sup_wb   = take && !own_hit && sup_m;
    bus_use  = !own_hit || (cur_wr && own_st == ST_S);
    base_blk = own_hit ? blk[gidx] : (sup_v ? blk[sup] : mem_rd);
    new_blk  = cur_wr ? put_word(base_blk, off, cur_wd) : base_blk;
    src      = own_hit ? SRC_LOCAL : (sup_v ? SRC_CACHE : SRC_MEM);
  end

  // next state for every cache at the shared index
  always_comb begin
    for (int j = 0; j < NCORES; j++) begin
      st_n[j]  = st[j];
      tag_n[j] = tg[j];
      blk_n[j] = blk[j];
      if (j == int'(gidx)) begin
        tag_n[j] = tag;
        blk_n[j] = new_blk;
        if (cur_wr)       st_n[j] = ST_M;
        else if (own_hit) st_n[j] = own_st;
        else              st_n[j] = sup_v ? ST_S : ST_E;
      end else if (hold[j]) begin
        if (cur_wr)       st_n[j] = ST_I;
        else if (own_hit) st_n[j] = st[j];
        else              st_n[j] = ST_S;
      end
    end
  end

  // ---------------- registered results ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done         <= '0;
      rdata        <= '0;
      trc_valid    <= 1'b0;
      trc_core     <= '0;
      trc_write    <= 1'b0;
      trc_addr     <= '0;
      trc_src      <= SRC_LOCAL;
      trc_src_core <= '0;
      trc_bus      <= 1'b0;
      trc_wb       <= 1'b0;
      trc_evict_wb <= 1'b0;
      trc_states   <= '0;
    end else begin
      done      <= grant;
      trc_valid <= take;
      if (take) begin
        rdata        <= get_word(new_blk, off);
        trc_core     <= gidx;
        trc_write    <= cur_wr;
        trc_addr     <= cur_addr;
        trc_src      <= src;
        trc_src_core <= (src == SRC_CACHE) ? sup : '0;
        trc_bus      <= bus_use;
        trc_wb       <= sup_wb;
        trc_evict_wb <= evict_wb;
        for (int j = 0; j < NCORES; j++)
          trc_states[2*j +: 2] <= (hold[j] || j == int'(gidx)) ? st_n[j] : ST_I;
      end
    end
  end

  // ---------------- assertions ----------------
  int n_live, n_excl;
  always_comb begin
    n_live = 0;
    n_excl = 0;
    for (int j = 0; j < NCORES; j++) begin
      if (trc_states[2*j +: 2] != ST_I) n_live++;
      if (trc_states[2*j +: 2] == ST_M || trc_states[2*j +: 2] == ST_E) n_excl++;
    end
  end

  // R2
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (done == $past(grant)) && trc_valid);

  // R4
  excl_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trc_valid && n_excl != 0) |-> (n_live == 1 && n_excl == 1));

  // R7
  read_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trc_valid && !trc_write && trc_src == SRC_LOCAL) |-> !trc_bus);

  // R10
  write_owns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trc_valid && trc_write) |-> trc_states[2*int'(trc_core) +: 2] == ST_M);

  // R6
  wb_from_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trc_valid && trc_wb) |-> trc_src == SRC_CACHE);
endmodule

// File: tb/tb_snoop_coherence_ctl.sv
module tb_snoop_coherence_ctl;
  localparam int NC = 3;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam logic [1:0] I = 2'd0, S = 2'd1, E = 2'd2, M = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0]    req_valid = '0, req_write = '0;
  logic [NC*AW-1:0] req_addr = '0;
  logic [NC*DW-1:0] req_wdata = '0;
  logic [NC-1:0]    req_ready, done;
  logic [DW-1:0]    rdata;
  logic             trc_valid, trc_write, trc_bus, trc_wb, trc_evict_wb;
  logic [1:0]       trc_core, trc_src_core, trc_src;
  logic [AW-1:0]    trc_addr;
  logic [2*NC-1:0]  trc_states;

  always #5 clk = ~clk;

  snoop_coherence_ctl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .trc_valid(trc_valid), .trc_core(trc_core),
    .trc_write(trc_write), .trc_addr(trc_addr), .trc_src(trc_src),
    .trc_src_core(trc_src_core), .trc_bus(trc_bus), .trc_wb(trc_wb),
    .trc_evict_wb(trc_evict_wb), .trc_states(trc_states)
  );

  typedef struct {
    int          core;
    bit          wr;
    logic [5:0]  addr;
    logic [1:0]  src;
    int          src_core;
    bit          bus, wb, ewb;
    logic [5:0]  states;
    logic [15:0] data;
    string       req;
  } exp_t;

  exp_t sbq[$];
  int n_checks = 0;
  int n_err = 0;
  int cyc = 0;

  function automatic logic [5:0] sv3(logic [1:0] c2, logic [1:0] c1, logic [1:0] c0);
    return {c2, c1, c0};
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
  endtask

  task automatic expect_item(int c, bit wr, logic [5:0] a, logic [1:0] src, int sc,
                             bit bus, bit wb, bit ewb, logic [5:0] st,
                             logic [15:0] d, string req);
    exp_t e;
    e.core = c; e.wr = wr; e.addr = a; e.src = src; e.src_core = sc;
    e.bus = bus; e.wb = wb; e.ewb = ewb; e.states = st; e.data = d; e.req = req;
    sbq.push_back(e);
  endtask

  task automatic drive(int c, bit wr, logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    req_valid[c] = 1'b1;
    req_write[c] = wr;
    req_addr[c*AW +: AW] = a;
    req_wdata[c*DW +: DW] = d;
    #1;
    while (!req_ready[c]) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    req_valid[c] = 1'b0;
  endtask

  // monitor: pop and compare each trace record
  always @(negedge clk) begin
    if (rst_n && trc_valid) begin
      n_checks++;
      if (sbq.size() == 0) begin
        n_err++;
        $display("FAIL R2: unexpected record core=%0d addr=%h, expected none", trc_core, trc_addr);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        if (int'(trc_core) != e.core || trc_write != e.wr || trc_addr != e.addr ||
            trc_src != e.src || int'(trc_src_core) != e.src_core || trc_bus != e.bus ||
            trc_wb != e.wb || trc_evict_wb != e.ewb || trc_states != e.states ||
            rdata != e.data || done != NC'(1 << e.core)) begin
          n_err++;
          $display("FAIL %s: got core=%0d wr=%0d addr=%h src=%0d sc=%0d bus=%0d wb=%0d ewb=%0d st=%b data=%h done=%b expected core=%0d wr=%0d addr=%h src=%0d sc=%0d bus=%0d wb=%0d ewb=%0d st=%b data=%h",
                   e.req, trc_core, trc_write, trc_addr, trc_src, trc_src_core, trc_bus,
                   trc_wb, trc_evict_wb, trc_states, rdata, done,
                   e.core, e.wr, e.addr, e.src, e.src_core, e.bus, e.wb, e.ewb, e.states, e.data);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_err++;
      $display("FAIL R2: watchdog cycles=%0d expected below %0d", cyc, 20000);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (done != '0 || trc_valid != 1'b0 || req_ready != '0) begin
      n_err++;
      $display("FAIL R1: after reset done=%b trc_valid=%b ready=%b, expected 0 0 0",
               done, trc_valid, req_ready);
    end

    // src: 0 local, 1 memory, 2 cache
    expect_item(0, 0, 6'h08, 2'd1, 0, 1, 0, 0, sv3(I, I, E), 16'hA008, "R4 R1");
    drive(0, 0, 6'h08, 16'h0);
    expect_item(0, 0, 6'h08, 2'd0, 0, 0, 0, 0, sv3(I, I, E), 16'hA008, "R7");
    drive(0, 0, 6'h08, 16'h0);
    expect_item(0, 1, 6'h08, 2'd0, 0, 0, 0, 0, sv3(I, I, M), 16'h1111, "R8 E");
    drive(0, 1, 6'h08, 16'h1111);
    expect_item(0, 1, 6'h08, 2'd0, 0, 0, 0, 0, sv3(I, I, M), 16'h2222, "R8 M");
    drive(0, 1, 6'h08, 16'h2222);
    expect_item(1, 0, 6'h08, 2'd2, 0, 1, 1, 0, sv3(I, S, S), 16'h2222, "R6");
    drive(1, 0, 6'h08, 16'h0);
    expect_item(2, 0, 6'h09, 2'd2, 0, 1, 0, 0, sv3(S, S, S), 16'hA009, "R5");
    drive(2, 0, 6'h09, 16'h0);
    expect_item(1, 1, 6'h09, 2'd0, 0, 1, 0, 0, sv3(I, M, I), 16'h3333, "R9");
    drive(1, 1, 6'h09, 16'h3333);
    expect_item(0, 1, 6'h08, 2'd2, 1, 1, 1, 0, sv3(I, I, M), 16'h4444, "R11 R10");
    drive(0, 1, 6'h08, 16'h4444);
    expect_item(2, 0, 6'h09, 2'd2, 0, 1, 1, 0, sv3(S, I, S), 16'h3333, "R6 R11");
    drive(2, 0, 6'h09, 16'h0);
    expect_item(1, 1, 6'h10, 2'd1, 0, 1, 0, 0, sv3(I, M, I), 16'h5555, "R10 nocopy");
    drive(1, 1, 6'h10, 16'h5555);
    expect_item(1, 0, 6'h18, 2'd1, 0, 1, 0, 1, sv3(I, E, I), 16'hA018, "R12 dirty");
    drive(1, 0, 6'h18, 16'h0);
    expect_item(2, 0, 6'h10, 2'd1, 0, 1, 0, 0, sv3(E, I, I), 16'h5555, "R12 silent");
    drive(2, 0, 6'h10, 16'h0);
    expect_item(0, 0, 6'h08, 2'd0, 0, 0, 0, 0, sv3(I, I, S), 16'h4444, "R7 S");
    drive(0, 0, 6'h08, 16'h0);

    // last grant was core 0, so simultaneous requests go 1, 2, 0
    expect_item(1, 0, 6'h24, 2'd1, 0, 1, 0, 0, sv3(I, E, I), 16'hA024, "R3 first");
    expect_item(2, 0, 6'h26, 2'd1, 0, 1, 0, 0, sv3(E, I, I), 16'hA026, "R3 second");
    expect_item(0, 0, 6'h22, 2'd1, 0, 1, 0, 0, sv3(I, I, E), 16'hA022, "R3 third");
    fork
      drive(0, 0, 6'h22, 16'h0);
      drive(1, 0, 6'h24, 16'h0);
      drive(2, 0, 6'h26, 16'h0);
    join

    repeat (4) @(negedge clk);
    n_checks++;
    if (sbq.size() != 0) begin
      n_err++;
      $display("FAIL R2: %0d records missing, expected 0", sbq.size());
    end
    summary();
    $finish;
  end
endmodule